// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Lines

A register-mapped general-purpose I/O bank, 32 pins by default, reached through a plain single-cycle write strobe with a combinational read port. Each pin has its own settings for direction, driven level, blinking and input inversion. Each incoming line passes through a multi-flop synchroniser. It is then optionally inverted to form the "pin view", which software reads back and which also feeds the interrupt logic.

Every pin offers two interrupt sources, each with its own enable. The level source follows the pin view directly and is not stored. The edge source is a sticky flag that is set when the pin view goes from 0 to 1. Falling edges are caught by inverting the pin first. Software clears flags by writing zeros to them. The enabled causes of each run of eight neighbouring pins are ORed onto one interrupt line, so 32 pins drive four lines.

A pin set as an output either drives its stored level or, with blinking on, a square wave whose half period is a parameter number of clock cycles.

Top module: `gpio_bank`

## Requirements
- R1: After reset, both interrupt-enable registers and the edge-flag register read 0, the direction register reads all ones (every pin an input), every output enable is 0 and every interrupt line is low.
- R2: Word-aligned byte offsets decode as: 0x00 drive level, 0x04 direction, 0x08 blink enable, 0x0C input inversion, 0x10 pin view (read-only), 0x14 edge flags, 0x18 edge enable, 0x1C level enable. Writable registers read back what was written. A write to 0x10 changes nothing.
- R3: A direction bit of 1 makes the pin an input, with its output enable at 0. A direction bit of 0 sets the output enable to 1 and drives the pin with its drive-level bit when blinking is off.
- R4: The pin view bit equals the synchronised pin input XOR the inversion bit. A change on a pin first appears in the view after the second rising clock edge. A change of the inversion bit appears at once.
- R5: The level cause of a pin is its view bit AND its level-enable bit and is not stored. When the pin view returns to 0, the cause goes away.
- R6: An edge flag bit is set one cycle after its view bit rises from 0 to 1, and it stays set after the pin falls. With the inversion bit at 1, a falling pin sets the flag.
- R7: Writing the edge-flag register clears every bit written as 0 and keeps every bit written as 1. A rising view bit in the same cycle as a clearing write leaves the flag set.
- R8: Interrupt line g is the OR of the combined causes ((view AND level enable) OR (flag AND edge enable)) of pins 8g through 8g+7.
- R9: An output pin with its blink bit set toggles every BLINK_DIV clock cycles instead of following its drive-level bit. An output pin without blinking holds its level.
- R10: A set edge flag raises no interrupt while its edge-enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for bus_addr, combinational |
| pin_i | input | NUM_PINS (32) | Asynchronous pin inputs |
| pad_out_o | output | NUM_PINS (32) | Value to drive on each pin |
| pad_oe_o | output | NUM_PINS (32) | Output enable per pin |
| irq_o | output | NUM_PINS/GROUP_SIZE (4) | Grouped interrupt lines |

## Verification
Some rules are checked by assertions on every cycle:
- The pin view matches the input from two cycles earlier once the inversion is removed.
- A rising view bit always leaves its flag set on the next cycle.
- Flags never drop without a write to the flag register.
- No interrupt line is high with both enables clear.
- An enabled level cause always reaches a line.

Other behaviours can only be shown by the bench's scenarios:
- the register decode and the read-only view;
- the exact clear-versus-set collision;
- the falling-edge capture through inversion;
- the pin-to-line grouping;
- the blink period.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   // Word index of each register (byte offset >> 2); software depends on it.
   typedef enum logic [2:0] {
      REG_DRIVE = 3'd0,
      REG_DIR   = 3'd1,
      REG_BLINK = 3'd2,
      REG_INV   = 3'd3,
      REG_VIEW  = 3'd4,
      REG_FLAG  = 3'd5,
      REG_EEN   = 3'd6,
      REG_LEN   = 3'd7
   } reg_idx_e;

   localparam int unsigned REG_IDX_W = 3;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q <= {stg_q[STAGES-2:0], din};
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
   parameter int unsigned DIV = 1024
) (
   input  logic clk,
   input  logic rst_n,
   output logic phase
);

   localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign phase = phase_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int unsigned       NUM_PINS = 32,
   parameter int unsigned       BUS_W    = 32,
   parameter int unsigned       ADDR_W   = 5,
   parameter logic [NUM_PINS-1:0] DIR_RST = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] view,
   input  logic [NUM_PINS-1:0] flag,
   output logic [NUM_PINS-1:0] drive_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] blink_q,
   output logic [NUM_PINS-1:0] inv_q,
   output logic [NUM_PINS-1:0] een_q,
   output logic [NUM_PINS-1:0] len_q,
   output logic                flag_wr,
   output logic [NUM_PINS-1:0] flag_keep
);

   reg_idx_e            idx;
   logic                aligned;
   logic                hit;
   logic [NUM_PINS-1:0] wval;

   assign idx     = reg_idx_e'(bus_addr[REG_IDX_W+1:2]);
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign hit     = bus_wr && aligned;
   assign wval    = bus_wdata[NUM_PINS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drive_q <= '0;
         dir_q   <= DIR_RST;
         blink_q <= '0;
         inv_q   <= '0;
         een_q   <= '0;
         len_q   <= '0;
      end else if (hit) begin
         case (idx)
            REG_DRIVE: drive_q <= wval;
            REG_DIR:   dir_q   <= wval;
            REG_BLINK: blink_q <= wval;
            REG_INV:   inv_q   <= wval;
            REG_EEN:   een_q   <= wval;
            REG_LEN:   len_q   <= wval;
            default:   ;
         endcase
      end
   end

   assign flag_wr   = hit && (idx == REG_FLAG);
   assign flag_keep = wval;

   always_comb begin
      bus_rdata = '0;
      case (idx)
         REG_DRIVE: bus_rdata[NUM_PINS-1:0] = drive_q;
         REG_DIR:   bus_rdata[NUM_PINS-1:0] = dir_q;
         REG_BLINK: bus_rdata[NUM_PINS-1:0] = blink_q;
         REG_INV:   bus_rdata[NUM_PINS-1:0] = inv_q;
         REG_VIEW:  bus_rdata[NUM_PINS-1:0] = view;
         REG_FLAG:  bus_rdata[NUM_PINS-1:0] = flag;
         REG_EEN:   bus_rdata[NUM_PINS-1:0] = een_q;
         REG_LEN:   bus_rdata[NUM_PINS-1:0] = len_q;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
   parameter int unsigned NUM_PINS   = 32,
   parameter int unsigned GROUP_SIZE = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PINS-1:0]            view,
   input  logic [NUM_PINS-1:0]            een,
   input  logic [NUM_PINS-1:0]            len,
   input  logic                           flag_wr,
   input  logic [NUM_PINS-1:0]            flag_keep,
   output logic [NUM_PINS-1:0]            flag_q,
   output logic [NUM_PINS/GROUP_SIZE-1:0] irq_o
);

   localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_SIZE;

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] cause;
   logic [NUM_PINS-1:0] flag_d;

   assign rise   = view & ~prev_q;
   // a new rising edge overrides a clearing write in the same cycle
   assign flag_d = (flag_q & (flag_wr ? flag_keep : {NUM_PINS{1'b1}})) | rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= view;
         flag_q <= flag_d;
      end
   end

   assign cause = (view & len) | (flag_q & een);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_line
      assign irq_o[g] = |cause[g*GROUP_SIZE +: GROUP_SIZE];
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned GROUP_SIZE  = 8,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BLINK_DIV   = 1024,
   localparam int unsigned NUM_GROUPS = NUM_PINS / GROUP_SIZE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic [NUM_PINS-1:0]   pin_i,
   output logic [NUM_PINS-1:0]   pad_out_o,
   output logic [NUM_PINS-1:0]   pad_oe_o,
   output logic [NUM_GROUPS-1:0] irq_o
);

   if (NUM_PINS % GROUP_SIZE != 0) begin : g_bad_group
      $error("NUM_PINS must be a multiple of GROUP_SIZE");
   end
   if (NUM_PINS > BUS_W) begin : g_bad_width
      $error("NUM_PINS must not exceed BUS_W");
   end
   if (ADDR_W != gpio_bank_pkg::REG_IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W must cover exactly eight word registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BLINK_DIV < 2) begin : g_bad_blink
      $error("BLINK_DIV must be at least 2");
   end

   logic [NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] pin_view;
   logic [NUM_PINS-1:0] drive_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] blink_q;
   logic [NUM_PINS-1:0] inv_q;
   logic [NUM_PINS-1:0] een_q;
   logic [NUM_PINS-1:0] len_q;
   logic [NUM_PINS-1:0] flag_q;
   logic [NUM_PINS-1:0] flag_keep;
   logic                flag_wr;
   logic                blink_phase;

   gpio_bank_sync #(
      .WIDTH (NUM_PINS),
      .STAGES(SYNC_STAGES)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_i),
      .dout (sync_q)
   );

   assign pin_view = sync_q ^ inv_q;

   gpio_bank_regs #(
      .NUM_PINS(NUM_PINS),
      .BUS_W   (BUS_W),
      .ADDR_W  (ADDR_W),
      .DIR_RST ({NUM_PINS{1'b1}})
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .view     (pin_view),
      .flag     (flag_q),
      .drive_q  (drive_q),
      .dir_q    (dir_q),
      .blink_q  (blink_q),
      .inv_q    (inv_q),
      .een_q    (een_q),
      .len_q    (len_q),
      .flag_wr  (flag_wr),
      .flag_keep(flag_keep)
   );

   gpio_bank_irq #(
      .NUM_PINS  (NUM_PINS),
      .GROUP_SIZE(GROUP_SIZE)
   ) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .view     (pin_view),
      .een      (een_q),
      .len      (len_q),
      .flag_wr  (flag_wr),
      .flag_keep(flag_keep),
      .flag_q   (flag_q),
      .irq_o    (irq_o)
   );

   gpio_bank_blink #(
      .DIV(BLINK_DIV)
   ) blink_i (
      .clk  (clk),
      .rst_n(rst_n),
      .phase(blink_phase)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      assign pad_oe_o[p]  = ~dir_q[p];
      assign pad_out_o[p] = blink_q[p] ? blink_phase : drive_q[p];
   end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned NUM_GROUPS  = 4,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [NUM_PINS-1:0]   pin_i,
   input logic [NUM_PINS-1:0]   view,
   input logic [NUM_PINS-1:0]   inv,
   input logic [NUM_PINS-1:0]   flag,
   input logic [NUM_PINS-1:0]   een,
   input logic [NUM_PINS-1:0]   len,
   input logic [NUM_GROUPS-1:0] irq_o
);

   logic [NUM_PINS-1:0] seen_q;
   logic [NUM_PINS-1:0] rise_c;
   logic [1:0]          warm_q;
   logic                flag_write;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q <= '0;
         warm_q <= '0;
      end else begin
         seen_q <= view;
         if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
   end

   assign rise_c     = view & ~seen_q;
   assign flag_write = bus_wr && (bus_addr[ADDR_W-1:2] == 3'd5) && (bus_addr[1:0] == 2'b00);

   // R4: view is the two-cycle-old pin value under inversion
   if (SYNC_STAGES == 2) begin : g_sync2
      p_view_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q >= 2'd2) |-> ((view ^ inv) == $past(pin_i, 2)));
   end

   // R6: a rising view bit is recorded on the next cycle
   p_flag_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag & $past(rise_c)) == $past(rise_c)));

   // R7: flags drop only through a write to the flag register
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_write |=> (($past(flag) & ~flag) == '0));

   // R10: no line is raised while every enable is clear
   p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o != '0) |-> ((een | len) != '0));

   // R5: an enabled level cause always reaches a line
   p_level_reaches_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((view & len) != '0) |-> (irq_o != '0));

endmodule

bind gpio_bank gpio_bank_chk #(
   .NUM_PINS   (NUM_PINS),
   .NUM_GROUPS (NUM_GROUPS),
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .bus_addr(bus_addr),
   .pin_i   (pin_i),
   .view    (pin_view),
   .inv     (inv_q),
   .flag    (flag_q),
   .een     (een_q),
   .len     (len_q),
   .irq_o   (irq_o)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

   localparam int unsigned NP = 32;
   localparam int unsigned NG = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_i = '0;
   logic [NP-1:0] pad_out_o;
   logic [NP-1:0] pad_oe_o;
   logic [NG-1:0] irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   gpio_bank #(.BLINK_DIV(4)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pin_i    (pin_i),
      .pad_out_o(pad_out_o),
      .pad_oe_o (pad_oe_o),
      .irq_o    (irq_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(idx * 4); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input int idx, output logic [31:0] v);
      bus_addr = 5'(idx * 4);
      #1 v = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_i = v;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd_reg(6, v); chk(v == 0, "R1 edge enable", v, 0);
      rd_reg(7, v); chk(v == 0, "R1 level enable", v, 0);
      rd_reg(5, v); chk(v == 0, "R1 flags", v, 0);
      rd_reg(1, v); chk(v == 32'hFFFF_FFFF, "R1 direction", v, 32'hFFFF_FFFF);
      chk(pad_oe_o == 0, "R1 output enables", pad_oe_o, 0);
      chk(irq_o == 0, "R1 irq lines", 32'(irq_o), 0);
   endtask

   task automatic t_regs;
      logic [31:0] v;
      wr_reg(0, 32'h1234_5678); rd_reg(0, v); chk(v == 32'h1234_5678, "R2 drive", v, 32'h1234_5678);
      wr_reg(1, 32'h0F0F_0F0F); rd_reg(1, v); chk(v == 32'h0F0F_0F0F, "R2 direction", v, 32'h0F0F_0F0F);
      wr_reg(2, 32'hA5A5_0000); rd_reg(2, v); chk(v == 32'hA5A5_0000, "R2 blink", v, 32'hA5A5_0000);
      wr_reg(3, 32'h0000_00FF); rd_reg(3, v); chk(v == 32'h0000_00FF, "R2 inversion", v, 32'h0000_00FF);
      // view is read-only: a write to 0x10 leaves it equal to pins ^ inversion
      wr_reg(4, 32'h5555_AAAA); rd_reg(4, v); chk(v == 32'h0000_00FF, "R2 view read-only", v, 32'h0000_00FF);
      wr_reg(6, 32'h8000_0001); rd_reg(6, v); chk(v == 32'h8000_0001, "R2 edge enable", v, 32'h8000_0001);
      wr_reg(7, 32'h0100_0100); rd_reg(7, v); chk(v == 32'h0100_0100, "R2 level enable", v, 32'h0100_0100);
      wr_reg(6, 0); wr_reg(7, 0);
      wr_reg(0, 0); wr_reg(2, 0); wr_reg(3, 0); wr_reg(1, 32'hFFFF_FFFF);
      settle(4);
      wr_reg(5, 0);
      rd_reg(5, v); chk(v == 0, "R7 flags cleared", v, 0);
   endtask

   task automatic t_direction;
      wr_reg(0, 32'h0000_A5A5);
      wr_reg(1, 32'hFFFF_0000);
      chk(pad_oe_o == 32'h0000_FFFF, "R3 output enables", pad_oe_o, 32'h0000_FFFF);
      chk(pad_out_o[15:0] == 16'hA5A5, "R3 driven levels", 32'(pad_out_o[15:0]), 32'hA5A5);
      wr_reg(1, 32'hFFFF_FFFF); wr_reg(0, 0);
      chk(pad_oe_o == 0, "R3 all inputs", pad_oe_o, 0);
   endtask

   task automatic t_view;
      logic [31:0] v;
      set_pins(32'h0000_0008);
      @(negedge clk); rd_reg(4, v); chk(v == 0, "R4 one edge: not yet", v, 0);
      @(negedge clk); rd_reg(4, v); chk(v == 32'h8, "R4 two edges: visible", v, 32'h8);
      wr_reg(3, 32'h0000_0018); rd_reg(4, v); chk(v == 32'h10, "R4 inversion", v, 32'h10);
      wr_reg(3, 0); set_pins(0); settle(4);
      wr_reg(5, 0);
   endtask

   task automatic t_level;
      wr_reg(7, 32'h8000_0001);
      chk(irq_o == 0, "R5 idle lines", 32'(irq_o), 0);
      set_pins(32'h1); settle(2);
      chk(irq_o == 4'b0001, "R5 level cause", 32'(irq_o), 1);
      set_pins(0); settle(2);
      chk(irq_o == 0, "R5 not stored", 32'(irq_o), 0);
      set_pins(32'h8000_0000); settle(2);
      chk(irq_o == 4'b1000, "R8 pin 31 to line 3", 32'(irq_o), 8);
      set_pins(0); settle(2);
      wr_reg(7, 0);
   endtask

   task automatic t_edge;
      logic [31:0] v;
      wr_reg(5, 0);
      set_pins(32'h400); settle(3);
      rd_reg(5, v); chk(v == 32'h400, "R6 rise sets flag", v, 32'h400);
      chk(irq_o == 0, "R10 flag without enable", 32'(irq_o), 0);
      wr_reg(6, 32'h400);
      chk(irq_o == 4'b0010, "R8 pin 10 to line 1", 32'(irq_o), 2);
      set_pins(0); settle(3);
      rd_reg(5, v); chk(v == 32'h400, "R6 flag held", v, 32'h400);
      chk(irq_o == 4'b0010, "R6 line held", 32'(irq_o), 2);
      wr_reg(6, 0);
      set_pins(32'h1000); settle(3);
      wr_reg(3, 32'h1000); settle(3);
      wr_reg(5, 0);
      set_pins(0); settle(3);
      rd_reg(5, v); chk(v == 32'h1000, "R6 falling via inversion", v, 32'h1000);
      wr_reg(3, 0); settle(3);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      set_pins(32'h400); settle(3);
      rd_reg(5, v); chk(v == 32'h1400, "R7 two flags", v, 32'h1400);
      wr_reg(5, ~32'h1000);
      rd_reg(5, v); chk(v == 32'h400, "R7 zero clears, one keeps", v, 32'h400);
      set_pins(32'h0010_0400);
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'd20; bus_wdata = 0;
      @(negedge clk);
      bus_wr = 1'b0;
      rd_reg(5, v); chk(v == 32'h0010_0000, "R7 set wins collision", v, 32'h0010_0000);
      set_pins(0); settle(3);
      wr_reg(5, 0);
      rd_reg(5, v); chk(v == 0, "R7 all cleared", v, 0);
   endtask

   task automatic t_blink;
      logic p4, p5;
      int tog4, tog5;
      wr_reg(0, 32'h30);
      wr_reg(2, 32'h10);
      wr_reg(1, ~32'h30);
      tog4 = 0; tog5 = 0;
      p4 = pad_out_o[4]; p5 = pad_out_o[5];
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (pad_out_o[4] != p4) tog4++;
         if (pad_out_o[5] != p5) tog5++;
         p4 = pad_out_o[4]; p5 = pad_out_o[5];
      end
      chk(tog4 == 4, "R9 blink toggles per 16 cycles", 32'(tog4), 4);
      chk(tog5 == 0 && p5 == 1'b1, "R9 steady output", 32'(tog5), 0);
      wr_reg(2, 0);
      chk(pad_out_o[4] == 1'b1, "R9 blink off follows level", 32'(pad_out_o[4]), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_regs;
      t_direction;
      t_view;
      t_level;
      t_edge;
      t_clear;
      t_blink;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule